// File: doc/BRIEF.md
# Dual-Mode Karatsuba Integer Multiplier

This block is a pipelined unsigned multiplier that serves two operand sizes from one pool of three 36x36 sub-multipliers. Each accepted operation carries a mode bit. A narrow operation packs two independent 36-bit operand pairs into the input buses and returns both 72-bit products side by side. A wide operation supplies one 60-bit operand pair and returns a single 120-bit product. The wide product is assembled from only three sub-products by a Karatsuba split of each operand into 30-bit halves.

The mode bit is sampled together with the operands and may change on any cycle. It travels down the pipeline with its data, so narrow and wide operations can be mixed in one stream without bubbles. Results leave a fixed three cycles after acceptance, with the mode echoed beside them so the consumer knows how to read the 144-bit result bus.

Top module: `kmul_dual_mult`

## Requirements
- R1: While reset is held and after it is released with no valid input, `out_valid` is 0 and `out_result` is all zeros.
- R2: In narrow mode (`in_wide`=0), `out_result[71:0]` equals `in_a[35:0]*in_b[35:0]` and `out_result[143:72]` equals `in_a[71:36]*in_b[71:36]`.
- R3: In wide mode (`in_wide`=1), `out_result[119:0]` equals `in_a[59:0]*in_b[59:0]` and `out_result[143:120]` is zero.
- R4: In wide mode, operand bits `in_a[71:60]` and `in_b[71:60]` have no effect on the result.
- R5: A valid input accepted on a clock edge produces `out_valid`=1 exactly three edges later, with `out_wide` equal to the accepted `in_wide`, in both modes.
- R6: The mode may differ between back-to-back valid inputs; every operation in an alternating stream gets the result of its own mode with no lost or inserted cycle.
- R7: Wide operands at the extremes (all ones, all zeros, high half all ones with low half zero, and the reverse) give exact products; the Karatsuba middle term never goes negative.
- R8: A cycle with `in_valid`=0 produces `out_valid`=0 three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the input bundle |
| in_wide | input | 1 | 1 = one 60-bit product, 0 = two 36-bit products |
| in_a | input | 72 | Operand A: narrow lanes in [35:0] and [71:36], wide operand in [59:0] |
| in_b | input | 72 | Operand B, same layout as `in_a` |
| out_valid | output | 1 | Result present on the output bundle |
| out_wide | output | 1 | Mode of the operation now on `out_result` |
| out_result | output | 144 | Two 72-bit products (narrow) or one zero-extended 120-bit product (wide) |

## Verification
The two functions that share a cycle are the narrow dual-lane product and the wide Karatsuba product: while one operation is being recombined at the output, an operation of the other mode sits in the sub-multipliers and a third is being split at the input. The bench provokes this with streams that alternate the mode on every cycle, interleaved with runs of random mode and idle gaps, and with wide corner operands whose upper unused bits carry garbage. A scoreboard records for each accepted operation the cycle it must appear in, its mode and its product computed from the requirements, and judges each output cycle against the head of that queue, so a mode leaking into a neighbour, a slipped cycle or a spurious valid is reported.

// File: rtl/kmul_pkg.sv
// Shared constants and types of the dual-mode multiplier.
// Assumes: unsigned operands only; the wide width is even and its half plus
// one carry bit fits the narrow sub-multiplier width.
package kmul_pkg;

    // Operation mode carried with every operand bundle.
    typedef enum logic {
        KMUL_NARROW = 1'b0,
        KMUL_WIDE   = 1'b1
    } kmul_mode_e;

    // Number of shared sub-multipliers (Karatsuba needs three).
    localparam int KMUL_LANES = 3;

endpackage

// File: rtl/kmul_operand_prep.sv
// Operand steering stage. Registers one bundle per cycle and routes it to the
// three sub-multiplier lanes: narrow mode feeds lanes 0 and 1 directly and
// zeros lane 2; wide mode feeds lo*lo, hi*hi and the half-sums product.
// Assumes NW > WW/2 + 1 so the half sums fit a lane.
module kmul_operand_prep
    import kmul_pkg::*;
#(
    parameter int NW = 36,
    parameter int WW = 60
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic                           in_wide,
    input  logic [2*NW-1:0]                in_a,
    input  logic [2*NW-1:0]                in_b,
    output logic                           s1_valid,
    output logic                           s1_wide,
    output logic [KMUL_LANES-1:0][NW-1:0]  op_a,
    output logic [KMUL_LANES-1:0][NW-1:0]  op_b
);

    localparam int HW = WW / 2;

    logic [HW-1:0]                  lo_a, hi_a, lo_b, hi_b;
    logic [HW:0]                    sum_a, sum_b;
    logic [KMUL_LANES-1:0][NW-1:0]  nxt_a, nxt_b;

    // Split the wide operands into halves and form the half sums.
    always_comb begin
        lo_a  = in_a[HW-1:0];
        hi_a  = in_a[WW-1:HW];
        lo_b  = in_b[HW-1:0];
        hi_b  = in_b[WW-1:HW];
        sum_a = {1'b0, hi_a} + {1'b0, lo_a};
        sum_b = {1'b0, hi_b} + {1'b0, lo_b};
    end

    // Select lane operands by mode; the idle narrow lane is held at zero.
    always_comb begin
        if (in_wide == KMUL_WIDE) begin
            nxt_a[0] = NW'(lo_a);
            nxt_b[0] = NW'(lo_b);
            nxt_a[1] = NW'(hi_a);
            nxt_b[1] = NW'(hi_b);
            nxt_a[2] = NW'(sum_a);
            nxt_b[2] = NW'(sum_b);
        end else begin
            nxt_a[0] = in_a[NW-1:0];
            nxt_b[0] = in_b[NW-1:0];
            nxt_a[1] = in_a[2*NW-1:NW];
            nxt_b[1] = in_b[2*NW-1:NW];
            nxt_a[2] = '0;
            nxt_b[2] = '0;
        end
    end

    // Capture the steered operands with their valid and mode tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_wide  <= 1'b0;
            op_a     <= '0;
            op_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_wide  <= in_wide;
            op_a     <= nxt_a;
            op_b     <= nxt_b;
        end
    end

    // R5: the valid tag advances exactly one stage per cycle.
    a_r5_stage1_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r8_stage1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);

    // R2: a narrow operation leaves the third lane quiet.
    a_r2_lane2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_wide) |-> (op_a[2] == '0 && op_b[2] == '0));

endmodule

// File: rtl/kmul_sub_mult.sv
// One registered unsigned W x W sub-multiplier lane.
// Assumes a single pipeline register is enough for the target clock.
module kmul_sub_mult #(
    parameter int W = 36
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    // Register the full-width product of the lane operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p <= '0;
        end else begin
            p <= (2*W)'(a) * (2*W)'(b);
        end
    end

endmodule

// File: rtl/kmul_recombine.sv
// Result assembly stage. Narrow mode concatenates lane products 1 and 0;
// wide mode forms hh<<WW + (mid-hh-ll)<<(WW/2) + ll at full width.
// Assumes lane products come from operands built by kmul_operand_prep.
module kmul_recombine
    import kmul_pkg::*;
#(
    parameter int NW = 36,
    parameter int WW = 60
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic                            in_wide,
    input  logic [KMUL_LANES-1:0][2*NW-1:0] prod,
    output logic                            out_valid,
    output logic                            out_wide,
    output logic [4*NW-1:0]                 out_result
);

    localparam int HW = WW / 2;
    localparam int PW = 2 * NW;
    localparam int RW = 4 * NW;

    logic [PW-1:0] mid;
    logic [RW-1:0] wide_sum, narrow_cat, nxt_result;

    // Karatsuba middle term and weighted sum of the three partial products.
    always_comb begin
        mid        = prod[2] - prod[1] - prod[0];
        wide_sum   = (RW'(prod[1]) << WW) + (RW'(mid) << HW) + RW'(prod[0]);
        narrow_cat = {prod[1], prod[0]};
        nxt_result = (in_wide == KMUL_WIDE) ? wide_sum : narrow_cat;
    end

    // Register the assembled result with its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_wide   <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= in_valid;
            out_wide   <= in_wide;
            out_result <= nxt_result;
        end
    end

    // R7: the cross product never falls below the sum of the outer products.
    a_r7_mid_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide) |->
            ({1'b0, prod[2]} >= ({1'b0, prod[0]} + {1'b0, prod[1]})));

endmodule

// File: rtl/kmul_dual_mult.sv
// Dual-mode multiplier top: operand steering, three shared sub-multiplier
// lanes, and result assembly; fixed latency of three cycles in both modes.
// Assumes a mode bit per operation; no back-pressure at either side.
module kmul_dual_mult
    import kmul_pkg::*;
#(
    parameter int NW = 36,
    parameter int WW = 60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_wide,
    input  logic [2*NW-1:0] in_a,
    input  logic [2*NW-1:0] in_b,
    output logic            out_valid,
    output logic            out_wide,
    output logic [4*NW-1:0] out_result
);

    localparam int PW = 2 * NW;

    logic                            s1_valid, s1_wide;
    logic [KMUL_LANES-1:0][NW-1:0]   op_a, op_b;
    logic [KMUL_LANES-1:0][PW-1:0]   prod;
    logic                            s2_valid, s2_wide;

    kmul_operand_prep #(.NW(NW), .WW(WW)) u_prep (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_wide  (in_wide),
        .in_a     (in_a),
        .in_b     (in_b),
        .s1_valid (s1_valid),
        .s1_wide  (s1_wide),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    for (genvar g = 0; g < KMUL_LANES; g++) begin : g_lane
        kmul_sub_mult #(.W(NW)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (op_a[g]),
            .b     (op_b[g]),
            .p     (prod[g])
        );
    end

    // Carry valid and mode alongside the multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_wide  <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            s2_wide  <= s1_wide;
        end
    end

    kmul_recombine #(.NW(NW), .WW(WW)) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s2_valid),
        .in_wide    (s2_wide),
        .prod       (prod),
        .out_valid  (out_valid),
        .out_wide   (out_wide),
        .out_result (out_result)
    );

    // R5, R6: each accepted operation appears three cycles later with its mode.
    a_r5_latency_mode: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (out_valid && (out_wide == $past(in_wide, 3))));

    // R3: a wide result keeps the bits above the product width at zero.
    a_r3_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wide) |-> (out_result[4*NW-1:2*WW] == '0));

    // R1: outputs are idle in the cycle after reset is applied.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));

endmodule

// File: tb/kmul_dual_mult_tb.sv
// Scoreboard bench: a driver pushes expected results with their due cycle,
// a monitor compares each output cycle against the queue head.
module kmul_dual_mult_tb;

    localparam int NW = 36;
    localparam int WW = 60;

    typedef struct {
        logic [143:0] res;
        logic         wide;
        int           due;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_wide = 1'b0;
    logic [71:0]  in_a = '0;
    logic [71:0]  in_b = '0;
    logic         out_valid, out_wide;
    logic [143:0] out_result;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    kmul_dual_mult #(.NW(NW), .WW(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_wide(out_wide),
        .out_result(out_result)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [143:0] ref_res(input logic wide,
                                             input logic [71:0] a,
                                             input logic [71:0] b);
        logic [143:0] r;
        if (wide) begin
            r = 144'(a[59:0]) * 144'(b[59:0]);
        end else begin
            r[71:0]   = 72'(a[35:0]) * 72'(b[35:0]);
            r[143:72] = 72'(a[71:36]) * 72'(b[71:36]);
        end
        return r;
    endfunction

    function automatic logic [71:0] rnd72();
        return {$urandom(), $urandom(), $urandom()} & {72{1'b1}};
    endfunction

    // Drive one operation (or an idle cycle) and record its expectation.
    task automatic drive(input bit v, input logic w, input logic [71:0] a,
                         input logic [71:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_wide  = w;
        in_a     = a;
        in_b     = b;
        if (v) begin
            e.res  = ref_res(w, a, b);
            e.wide = w;
            e.due  = cyc + 3;
            e.tag  = tag;
            sb.push_back(e);
        end
    endtask

    // Monitor: judge every output cycle against the scoreboard head.
    always @(negedge clk) begin
        if (mon_en) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (!out_valid || out_wide !== e.wide || out_result !== e.res) begin
                    errors++;
                    $display("FAIL %s/R5: valid=%0b wide=%0b res=%h expected valid=1 wide=%0b res=%h",
                             e.tag, out_valid, out_wide, out_result, e.wide, e.res);
                end
            end else if (out_valid !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R8: out_valid=%0b expected 0 at cycle %0d", out_valid, cyc);
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b res=%h expected valid=0 res=0", out_valid, out_result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b res=%h expected valid=0 res=0 after release", out_valid, out_result);
        end

        // R2: narrow corners and random
        drive(1, 0, '0, '0, "R2");
        drive(1, 0, '1, '1, "R2");
        drive(1, 0, {36'h0, 36'hFFFFFFFFF}, {36'hFFFFFFFFF, 36'h1}, "R2");
        for (int i = 0; i < 20; i++) drive(1, 0, rnd72(), rnd72(), "R2");

        // R3 and R7: wide corners
        drive(1, 1, 72'(60'hFFFFFFFFFFFFFFF), 72'(60'hFFFFFFFFFFFFFFF), "R7");
        drive(1, 1, '0, 72'(60'hFFFFFFFFFFFFFFF), "R7");
        drive(1, 1, 72'({30'h3FFFFFFF, 30'h0}), 72'({30'h3FFFFFFF, 30'h0}), "R7");
        drive(1, 1, 72'({30'h0, 30'h3FFFFFFF}), 72'({30'h3FFFFFFF, 30'h0}), "R7");
        for (int i = 0; i < 20; i++)
            drive(1, 1, 72'(rnd72() & 72'hFFFFFFFFFFFFFFF), 72'(rnd72() & 72'hFFFFFFFFFFFFFFF), "R3");

        // R4: wide with garbage in the unused upper bits
        drive(1, 1, {12'hFFF, 60'h123456789ABCDEF}, {12'hA5A, 60'hFEDCBA987654321}, "R4");
        for (int i = 0; i < 10; i++) drive(1, 1, rnd72(), rnd72(), "R4");

        // R6: mode alternates on every cycle
        for (int i = 0; i < 30; i++) drive(1, i[0], rnd72(), rnd72(), "R6");

        // R8: idle gaps mixed with random modes
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom_range(0, 3);
            if (r == 0) drive(0, 1'($urandom()), rnd72(), rnd72(), "R8");
            else        drive(1, 1'($urandom()), rnd72(), rnd72(), "R6");
        end

        drive(0, 0, '0, '0, "R8");
        repeat (6) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule